// File: doc/BRIEF.md
# Read-Capture Phase Sweep Calibrator

This block finds the capture phase at which a read data path samples reliably. After a start pulse it walks a resynchronization clock through every phase position of a sweep. The sweep covers one memory clock cycle or two, as a parameter selects. At each position it asks an external test-read agent for one read and records whether that read passed. Each phase move is a single step pulse to an external clock generator, which must acknowledge it.

When the sweep ends, the block sorts the pass/fail profile into one of three outcomes: no passing position, exactly one contiguous passing window, or several windows. With one window, it steps the phase forward to the window centre. It performs one more test read there and keeps the latency that read returns. It then publishes the centre position, the window width and that latency, and pulses done. In the other two outcomes it raises the matching error flag and pulses done at once, with no further phase movement.

The clock generator, the memory and the test pattern logic sit outside the block. The block counts phase steps itself, modulo the number of sweep positions. A new calibration therefore first steps the phase forward until it is back at position 0.

Top module: `phase_sweep_cal`

## Requirements
- R1: The sweep has N positions, with N = STEPS_PER_CYCLE in one-cycle mode (TWO_CYCLE=0) and N = 2*STEPS_PER_CYCLE in two-cycle mode. Exactly one read request is made at each position, in the order 0, 1, ..., N-1.
- R2: Each phase move is a `step_o` pulse lasting one clock. After a pulse, no further step pulse and no read request is issued until `step_ack_i` has been seen.
- R3: `rd_req_o` stays high until `rd_done_i`. The `rd_pass_i` value sampled with `rd_done_i` (1 = pass) grades the current phase position.
- R4: In the clock after an accepted `start_i`, `done_o`, both error flags, `win_size_o`, `centre_o` and `rd_lat_o` are 0, and they stay 0 until done. If the phase count is not 0 at start, step pulses are issued until it is 0 before the first read.
- R5: A window is a run of adjacent passing positions. In one-cycle mode a run that reaches position N-1 and a run that starts at position 0 form one window. In two-cycle mode they are separate windows.
- R6: On success, `centre_o` = (window start + floor(window size / 2)) mod N. When every position passes in one-cycle mode, the window start is 0.
- R7: On success, step pulses move the phase from N-1 forward (wrapping through 0) to the centre. One more read is made there, and `rd_lat_o` reports the `rd_lat_i` value returned by that read.
- R8: On success, `win_size_o` equals the number of passing positions in the window.
- R9: If no position passes, `err_none_o` = 1 and `win_size_o`, `centre_o` and `rd_lat_o` are 0. Done follows the sweep with no further step or read.
- R10: If more than one window is seen, `err_multi_o` = 1 and `win_size_o`, `centre_o` and `rd_lat_o` are 0. Done follows the sweep with no further step or read. The two error flags are never both 1.
- R11: `done_o` is a one-clock pulse. The published outputs then hold their values until the next start.
- R12: After reset all outputs are 0, and the phase count is taken to be 0, so the first calibration reads position 0 with no step before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a calibration (one-clock pulse) |
| step_o | output | 1 | One-clock pulse that advances the resync phase by one step |
| step_ack_i | input | 1 | Clock generator reports that the step has taken effect |
| rd_req_o | output | 1 | Test-read request, held until the result arrives |
| rd_done_i | input | 1 | Test-read result is valid |
| rd_pass_i | input | 1 | Test-read graded as pass (1) or fail (0) |
| rd_lat_i | input | LAT_W | Read latency in PHY clocks measured by the test read |
| done_o | output | 1 | One-clock pulse at the end of calibration |
| centre_o | output | clog2(N) | Phase step count of the window centre |
| win_size_o | output | clog2(N+1) | Passing positions in the window |
| rd_lat_o | output | LAT_W | Read latency measured at the centre phase |
| err_none_o | output | 1 | No passing position found |
| err_multi_o | output | 1 | More than one passing window found |

## Verification
The checker assumes `start_i` arrives only while the block is idle, that is, before the first start or after done. It also assumes `step_ack_i` and `rd_done_i` come only as one-clock answers to a step or request that is still open. The bench keeps to these rules. It models the clock generator and the memory as responders that answer each step and each request exactly once after a chosen delay, and it issues start only after both instances have reported done. Both sweep lengths run side by side on profiles chosen to hit the wrap merge, the centre at the last position, full passes, single passes and empty profiles.

// File: rtl/calib_pkg.sv
package calib_pkg;

    localparam int MAXW = 8;
    localparam int RW   = MAXW + 1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REW_STEP,
        S_REW_WAIT,
        S_SWP_READ,
        S_SWP_STEP,
        S_SWP_WAIT,
        S_CLASSIFY,
        S_CTR_STEP,
        S_CTR_WAIT,
        S_FIN_READ,
        S_PUBLISH
    } cal_state_e;

    typedef struct packed {
        logic            none;
        logic            multi;
        logic [RW-1:0]   size;
        logic [MAXW-1:0] centre;
    } win_res_t;

    function automatic logic [RW-1:0] mod_n(input logic [RW-1:0] v, input int n);
        return (v >= RW'(n)) ? v - RW'(n) : v;
    endfunction

endpackage

// File: rtl/calib_phase_count.sv
module calib_phase_count #(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    output logic [PW-1:0] phase_o
);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst)
            phase_o <= '0;
        else if (step_i)
            phase_o <= (phase_o == LAST) ? '0 : phase_o + 1'b1;
    end
endmodule

// File: rtl/calib_pass_map.sv
module calib_pass_map #(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [PW-1:0] idx_i,
    input  logic          pass_i,
    output logic [N-1:0]  map_o
);
    always_ff @(posedge clk) begin
        if (rst)
            map_o <= '0;
        else if (wr_i)
            map_o[idx_i] <= pass_i;
    end
endmodule

// File: rtl/calib_window_finder.sv
module calib_window_finder
    import calib_pkg::*;
#(
    parameter int N    = 8,
    parameter bit WRAP = 1'b1
) (
    input  logic [N-1:0] map_i,
    output win_res_t     res_o
);
    logic [N-1:0]    rise;
    logic [RW-1:0]   n_pass;
    logic [RW-1:0]   n_rise;
    logic [MAXW-1:0] first;
    logic            found;
    logic [RW-1:0]   mid;

    // position 0 has a left neighbour only when the sweep is circular
    generate
        if (WRAP) begin : g_circ
            assign rise[0] = map_i[0] & ~map_i[N-1];
        end else begin : g_line
            assign rise[0] = map_i[0];
        end
        for (genvar i = 1; i < N; i++) begin : g_rise
            assign rise[i] = map_i[i] & ~map_i[i-1];
        end
    endgenerate

    always_comb begin
        n_pass = '0;
        n_rise = '0;
        first  = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            n_pass = n_pass + {{(RW-1){1'b0}}, map_i[i]};
            n_rise = n_rise + {{(RW-1){1'b0}}, rise[i]};
            if (rise[i] && !found) begin
                first = MAXW'(i);
                found = 1'b1;
            end
        end
        // an all-pass circular profile has no rising edge: start stays 0
        mid = mod_n({1'b0, first} + {1'b0, n_pass[RW-1:1]}, N);
        res_o.none   = (n_pass == '0);
        res_o.multi  = (n_rise > RW'(1));
        res_o.size   = n_pass;
        res_o.centre = mid[MAXW-1:0];
    end
endmodule

// File: rtl/phase_sweep_cal.sv
module phase_sweep_cal
    import calib_pkg::*;
#(
    parameter int STEPS_PER_CYCLE = 8,
    parameter bit TWO_CYCLE       = 1'b0,
    parameter int LAT_W           = 4,
    localparam int N  = STEPS_PER_CYCLE * (TWO_CYCLE ? 2 : 1),
    localparam int PW = (N > 1) ? $clog2(N) : 1,
    localparam int SW = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             step_o,
    input  logic             step_ack_i,
    output logic             rd_req_o,
    input  logic             rd_done_i,
    input  logic             rd_pass_i,
    input  logic [LAT_W-1:0] rd_lat_i,
    output logic             done_o,
    output logic [PW-1:0]    centre_o,
    output logic [SW-1:0]    win_size_o,
    output logic [LAT_W-1:0] rd_lat_o,
    output logic             err_none_o,
    output logic             err_multi_o
);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    cal_state_e       st_q, st_d;
    logic [PW-1:0]    phase;
    logic [N-1:0]     map;
    logic             map_wr;
    win_res_t         res_now, res_q;
    logic [LAT_W-1:0] lat_q;
    logic [PW-1:0]    centre_ph;
    logic             res_bad;

    assign step_o    = (st_q == S_REW_STEP) || (st_q == S_SWP_STEP) || (st_q == S_CTR_STEP);
    assign rd_req_o  = (st_q == S_SWP_READ) || (st_q == S_FIN_READ);
    assign map_wr    = (st_q == S_SWP_READ) && rd_done_i;
    assign centre_ph = res_q.centre[PW-1:0];
    assign res_bad   = res_q.none || res_q.multi;

    calib_phase_count #(.N(N), .PW(PW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step_o),
        .phase_o (phase)
    );

    calib_pass_map #(.N(N), .PW(PW)) u_map (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (map_wr),
        .idx_i  (phase),
        .pass_i (rd_pass_i),
        .map_o  (map)
    );

    calib_window_finder #(.N(N), .WRAP(!TWO_CYCLE)) u_finder (
        .map_i (map),
        .res_o (res_now)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:     if (start_i) st_d = (phase != '0) ? S_REW_STEP : S_SWP_READ;
            S_REW_STEP: st_d = S_REW_WAIT;
            S_REW_WAIT: if (step_ack_i) st_d = (phase == '0) ? S_SWP_READ : S_REW_STEP;
            S_SWP_READ: if (rd_done_i) st_d = (phase == LAST) ? S_CLASSIFY : S_SWP_STEP;
            S_SWP_STEP: st_d = S_SWP_WAIT;
            S_SWP_WAIT: if (step_ack_i) st_d = S_SWP_READ;
            S_CLASSIFY: begin
                if (res_now.none || res_now.multi)
                    st_d = S_PUBLISH;
                else if (phase == res_now.centre[PW-1:0])
                    st_d = S_FIN_READ;
                else
                    st_d = S_CTR_STEP;
            end
            S_CTR_STEP: st_d = S_CTR_WAIT;
            S_CTR_WAIT: if (step_ack_i) st_d = (phase == centre_ph) ? S_FIN_READ : S_CTR_STEP;
            S_FIN_READ: if (rd_done_i) st_d = S_PUBLISH;
            S_PUBLISH:  st_d = S_IDLE;
            default:    st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            res_q       <= '0;
            lat_q       <= '0;
            done_o      <= 1'b0;
            centre_o    <= '0;
            win_size_o  <= '0;
            rd_lat_o    <= '0;
            err_none_o  <= 1'b0;
            err_multi_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= 1'b0;
            if (st_q == S_IDLE && start_i) begin
                res_q       <= '0;
                lat_q       <= '0;
                centre_o    <= '0;
                win_size_o  <= '0;
                rd_lat_o    <= '0;
                err_none_o  <= 1'b0;
                err_multi_o <= 1'b0;
            end
            if (st_q == S_CLASSIFY)
                res_q <= res_now;
            if (st_q == S_FIN_READ && rd_done_i)
                lat_q <= rd_lat_i;
            if (st_q == S_PUBLISH) begin
                done_o      <= 1'b1;
                err_none_o  <= res_q.none;
                err_multi_o <= res_q.multi;
                win_size_o  <= res_bad ? '0 : res_q.size[SW-1:0];
                centre_o    <= res_bad ? '0 : centre_ph;
                rd_lat_o    <= res_bad ? '0 : lat_q;
            end
        end
    end
endmodule

// File: rtl/calib_checks.sv
module calib_checks #(
    parameter int N  = 8,
    parameter int PW = 3,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          step_o,
    input logic          rd_req_o,
    input logic          rd_done_i,
    input logic          done_o,
    input logic [PW-1:0] centre_o,
    input logic [SW-1:0] win_size_o,
    input logic          err_none_o,
    input logic          err_multi_o
);
    assert_step_single_R2: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);

    assert_step_no_read_R2: assert property (@(posedge clk) disable iff (rst)
        step_o |-> !rd_req_o);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_done_i) |=> rd_req_o);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && !err_none_o && !err_multi_o && win_size_o == '0 && centre_o == '0));

    assert_centre_range_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (centre_o <= PW'(N - 1)));

    assert_size_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_none_o && !err_multi_o) |-> (win_size_o != '0));

    assert_none_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_none_o) |-> done_o);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(err_none_o && err_multi_o));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (done_o || ($stable(win_size_o) && $stable(centre_o) && $stable(err_none_o))));
endmodule

bind phase_sweep_cal calib_checks #(.N(N), .PW(PW), .SW(SW)) u_calib_checks (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .step_o      (step_o),
    .rd_req_o    (rd_req_o),
    .rd_done_i   (rd_done_i),
    .done_o      (done_o),
    .centre_o    (centre_o),
    .win_size_o  (win_size_o),
    .err_none_o  (err_none_o),
    .err_multi_o (err_multi_o)
);

// File: tb/phase_sweep_cal_bench.sv
module phase_sweep_cal_bench;
    localparam int S = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    always #4 clk = ~clk;

    logic       step_v[2], ack_v[2], req_v[2], rdone_v[2], rpass_v[2];
    logic       done_v[2], en_v[2], em_v[2];
    logic [3:0] rlat_v[2], lato_v[2];
    logic [2:0] cen_a;
    logic [3:0] cen_b;
    logic [3:0] sz_a;
    logic [4:0] sz_b;

    phase_sweep_cal #(.STEPS_PER_CYCLE(S), .TWO_CYCLE(1'b0), .LAT_W(4)) u_phase_sweep_cal (
        .clk(clk), .rst(rst), .start_i(start),
        .step_o(step_v[0]), .step_ack_i(ack_v[0]),
        .rd_req_o(req_v[0]), .rd_done_i(rdone_v[0]), .rd_pass_i(rpass_v[0]), .rd_lat_i(rlat_v[0]),
        .done_o(done_v[0]), .centre_o(cen_a), .win_size_o(sz_a), .rd_lat_o(lato_v[0]),
        .err_none_o(en_v[0]), .err_multi_o(em_v[0])
    );

    phase_sweep_cal #(.STEPS_PER_CYCLE(S), .TWO_CYCLE(1'b1), .LAT_W(4)) u_phase_sweep_cal_wide (
        .clk(clk), .rst(rst), .start_i(start),
        .step_o(step_v[1]), .step_ack_i(ack_v[1]),
        .rd_req_o(req_v[1]), .rd_done_i(rdone_v[1]), .rd_pass_i(rpass_v[1]), .rd_lat_i(rlat_v[1]),
        .done_o(done_v[1]), .centre_o(cen_b), .win_size_o(sz_b), .rd_lat_o(lato_v[1]),
        .err_none_o(en_v[1]), .err_multi_o(em_v[1])
    );

    int checks = 0;
    int errors = 0;
    int         nsteps[2] = '{S, 2 * S};
    logic [15:0] prof[2];
    int ack_dly[2], rd_dly[2], ph[2], ack_cnt[2], rd_cnt[2], rcnt[2];
    bit pend[2], rd_busy[2], busy[2], arm[2], done_seen[2], prev_done[2];
    int rseq[2][0:39];

    function automatic int lat_of(int p);
        return 2 + (p % 5);
    endfunction

    function automatic int cen_of(int g);
        return (g == 0) ? int'(cen_a) : int'(cen_b);
    endfunction

    function automatic int sz_of(int g);
        return (g == 0) ? int'(sz_a) : int'(sz_b);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // expected outcome straight from the window rules
    function automatic void ref_calc(input int n, input bit wrap, input logic [15:0] p,
                                     output int none, output int multi,
                                     output int size, output int centre);
        int rises = 0;
        int first = -1;
        size = 0;
        for (int i = 0; i < n; i++) begin
            bit prev;
            if (p[i]) size++;
            prev = (i == 0) ? (wrap ? p[n-1] : 1'b0) : p[i-1];
            if (p[i] && !prev) begin
                rises++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) first = 0;
        none   = (size == 0);
        multi  = (rises > 1);
        centre = (first + size / 2) % n;
    endfunction

    initial begin
        for (int g = 0; g < 2; g++) begin
            ack_v[g] = 0; rdone_v[g] = 0; rpass_v[g] = 0; rlat_v[g] = '0;
            ph[g] = 0; pend[g] = 0; rd_busy[g] = 0; busy[g] = 0; arm[g] = 0;
            done_seen[g] = 0; prev_done[g] = 0; rcnt[g] = 0; ack_cnt[g] = 0; rd_cnt[g] = 0;
            ack_dly[g] = 0; rd_dly[g] = 0; prof[g] = '0;
        end
    end

    // clock generator and memory responders, plus per-clock protocol checks
    always @(negedge clk) begin
        if (!rst) begin
            for (int g = 0; g < 2; g++) begin
                ack_v[g]   = 1'b0;
                rdone_v[g] = 1'b0;
                if (arm[g]) begin busy[g] = 1; arm[g] = 0; end
                if (start) begin arm[g] = 1; done_seen[g] = 0; rcnt[g] = 0; end
                if (pend[g]) begin
                    if (ack_cnt[g] > 0) ack_cnt[g]--;
                    else begin ack_v[g] = 1'b1; pend[g] = 0; end
                end
                if (step_v[g]) begin
                    chk("R2", "step issued while step or read open", int'(pend[g] || req_v[g]), 0);
                    ph[g] = (ph[g] + 1) % nsteps[g];
                    pend[g] = 1;
                    ack_cnt[g] = ack_dly[g];
                end
                if (req_v[g] && pend[g])
                    chk("R2", "read requested before step ack", 1, 0);
                if (rd_busy[g]) begin
                    chk("R3", "request dropped before result", int'(req_v[g]), 1);
                    if (rd_cnt[g] > 0) rd_cnt[g]--;
                    else begin
                        rdone_v[g] = 1'b1;
                        rpass_v[g] = prof[g][ph[g]];
                        rlat_v[g]  = 4'(lat_of(ph[g]));
                        rd_busy[g] = 0;
                    end
                end else if (req_v[g]) begin
                    rd_busy[g] = 1;
                    rd_cnt[g] = rd_dly[g];
                    if (rcnt[g] < 40) rseq[g][rcnt[g]] = ph[g];
                    rcnt[g]++;
                end
                if (busy[g] && !done_v[g])
                    chk("R4", "status not clear while running",
                        int'(en_v[g]) + int'(em_v[g]) + sz_of(g) + cen_of(g) + int'(lato_v[g]), 0);
                if (done_v[g]) begin
                    chk("R11", "done longer than one clock", int'(prev_done[g]), 0);
                    done_seen[g] = 1;
                    busy[g] = 0;
                end
                prev_done[g] = done_v[g];
            end
        end
    end

    task automatic verify(input int g, input logic [15:0] p);
        int none, multi, size, centre, exp_len;
        ref_calc(nsteps[g], (g == 0), p, none, multi, size, centre);
        chk("R9", "no-window flag", int'(en_v[g]), none);
        chk("R10", "multi-window flag", int'(em_v[g]), (none == 0) ? multi : 0);
        if (none != 0 || multi != 0) begin
            chk("R9", "size on error", sz_of(g), 0);
            chk("R10", "centre and latency on error", cen_of(g) + int'(lato_v[g]), 0);
            exp_len = nsteps[g];
        end else begin
            chk("R8", "window size", sz_of(g), size);
            chk("R6", "centre", cen_of(g), centre);
            chk("R7", "latency at centre", int'(lato_v[g]), lat_of(centre));
            chk("R5", "window classified as single", int'(em_v[g]), 0);
            exp_len = nsteps[g] + 1;
        end
        chk("R1", "number of reads", rcnt[g], exp_len);
        chk("R4", "first read at phase 0", rseq[g][0], 0);
        for (int i = 0; i < nsteps[g] && i < rcnt[g]; i++)
            chk("R1", "sweep read phase", rseq[g][i], i);
        if (exp_len > nsteps[g] && rcnt[g] > nsteps[g])
            chk("R7", "final read phase", rseq[g][nsteps[g]], centre);
    endtask

    task automatic run(input logic [15:0] pa, input logic [15:0] pb, input int da, input int db);
        int t = 0;
        int hold_sz[2], hold_cen[2], hold_lat[2];
        prof[0] = pa; prof[1] = pb;
        ack_dly[0] = da; ack_dly[1] = db;
        rd_dly[0] = db;  rd_dly[1] = da;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        while (!(done_seen[0] && done_seen[1]) && t < 4000) begin
            @(negedge clk); #1;
            t++;
        end
        if (t >= 4000) chk("R11", "calibration never finished", 0, 1);
        verify(0, pa);
        verify(1, pb);
        for (int g = 0; g < 2; g++) begin
            hold_sz[g] = sz_of(g); hold_cen[g] = cen_of(g); hold_lat[g] = int'(lato_v[g]);
        end
        repeat (3) @(negedge clk);
        #1;
        for (int g = 0; g < 2; g++)
            chk("R11", "results held after done",
                sz_of(g) + 16 * cen_of(g) + 256 * int'(lato_v[g]),
                hold_sz[g] + 16 * hold_cen[g] + 256 * hold_lat[g]);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        for (int g = 0; g < 2; g++) begin
            chk("R12", "outputs after reset",
                int'(done_v[g]) + int'(en_v[g]) + int'(em_v[g]) + sz_of(g) + cen_of(g) + int'(lato_v[g])
                + int'(step_v[g]) + int'(req_v[g]), 0);
        end
        run(16'h003C, 16'h0FF0, 0, 2);  // plain windows
        run(16'h00C3, 16'h8001, 1, 0);  // wrap merge vs two windows
        run(16'h0000, 16'hFFFF, 2, 1);  // empty vs full
        run(16'h00FF, 16'h8000, 0, 0);  // full circle vs last step only
        run(16'h0024, 16'h0000, 1, 2);  // two windows vs empty
        run(16'h000E, 16'h0001, 2, 0);  // odd width vs first step only
        run(16'h0080, 16'h7FFE, 1, 1);  // centre on last step
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule